// File: doc/BRIEF.md
# Dual H-Bridge Gate Sequencer

This block produces the gate enable bits for two full H-bridges, one per stator winding of a two-phase motor. Each bridge has two legs, and each leg has a high-side and a low-side switch. A controller asks for a bridge state per winding: off, forward, reverse, slow decay or fast decay. The block turns that request into the four gate bits of each bridge. It inserts a programmable break-before-make gap whenever a leg changes sides. It latches a shutdown when a conducting switch reports desaturation. It also turns on a switch that carries reverse current, so that the current flows through its channel and not through its body diode.

A single drive enable puts every switch of both bridges off, which leaves the motor terminals high-impedance. Clearing the drive enable is also the only way to clear a latched bridge fault. Every gate bit is registered, so a change of request shows at the outputs one clock later. The dead time can add cycles to that.

Top module: `hb_gate_seq`

## Requirements
- R1: While `drive_en` is 0, every bit of `gate_on` is 0 on the clock edge that follows. After reset, all gates and fault bits are 0.
- R2: Bridge b uses gate bits `gate_on[4b+3:4b]`. The bit order is: bit 0 high-side of leg A, bit 1 low-side of leg A, bit 2 high-side of leg B, bit 3 low-side of leg B. The command codes map to these patterns:
  - 3'b000 gives 4'b0000.
  - 3'b001 (forward) gives 4'b1001.
  - 3'b010 (reverse) gives 4'b0110.
  - 3'b011 (slow decay, both low-sides) gives 4'b1010.
  - 3'b101, 3'b110 and 3'b111 give 4'b0000.
- R3: The high-side and low-side gates of one leg are never 1 in the same cycle.
- R4: A switch turns on while the other switch of its leg was the last one on in that leg. Before it turns on, both gates of the leg stay 0 for D whole cycles, where D is `dead_cycles` (the value 0 counts as 1). D is exactly the gap when the request is held. No gap is added when the same switch was last on, or when neither switch has been on since reset.
- R5: Code 3'b100 (fast decay) gives the opposite polarity of the last forward or reverse command that was accepted while enabled. After a reverse command it gives 4'b1001, and after a forward command it gives 4'b0110. The last command counts as forward after reset.
- R6: A desaturation flag on a switch whose gate is 1, while enabled, sets that bridge's `bridge_fault` on the next edge. All four of its gates are 0 in that same cycle. The other bridge is not affected. A flag on a switch whose gate is 0 has no effect.
- R7: A set fault holds, and keeps the bridge's gates at 0 whatever the command, until `drive_en` is 0. It is 0 on the edge after that. After the enable returns, commands drive the bridge again.
- R8: A reverse-current flag on a switch that is not commanded on requests that switch. The request applies only when the other switch of the leg is neither commanded nor flagged. The request is subject to R3 and R4, and it is dropped when the flag goes to 0. It has no effect while the bridge is disabled or faulted.
- R9: A switch whose request is withdrawn is 0 on the next clock edge, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | Global bridge enable; 0 forces all switches off and clears faults |
| dead_cycles | input | DT_W | Break-before-make gap in cycles, 1 to 15 (0 acts as 1) |
| bridge_cmd | input | 3*NUM_BRIDGES | Requested state per bridge, 3 bits each, bridge 0 in the low bits |
| desat_flag | input | 4*NUM_BRIDGES | Per-switch excessive drain-source voltage indication |
| rev_flag | input | 4*NUM_BRIDGES | Per-switch reverse (source to drain) current indication |
| gate_on | output | 4*NUM_BRIDGES | Gate enable per switch, bit order as in R2 |
| bridge_fault | output | NUM_BRIDGES | Latched desaturation shutdown per bridge |

## Verification
Two functions can act on the same leg in the same cycle.

The first pair is a reverse-current request and a running dead-time gap. A flag can appear on a switch while its leg is waiting out a side change. The switch must then still honour the gap. It must also give way when its partner is the commanded side.

The second pair is a desaturation trip and a new command. The trip can land on the very edge where a new command arrives, and the shutdown must win.

Both cases are first provoked in directed steps. They are then provoked again in a long randomized stream of commands, flags, dead times and enable drops. A behavioural model of the requirements judges every gate and fault bit on every clock.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    localparam int SW_PER_BRIDGE = 4;
    localparam int CMD_W         = 3;

    typedef enum logic [2:0] {
        CMD_OFF  = 3'b000,
        CMD_FWD  = 3'b001,
        CMD_REV  = 3'b010,
        CMD_SLOW = 3'b011,
        CMD_FAST = 3'b100
    } bridge_cmd_e;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HI   = 2'd1,
        SIDE_LO   = 2'd2
    } side_e;

    // Switch order: [0] hi leg A, [1] lo leg A, [2] hi leg B, [3] lo leg B
    function automatic logic [SW_PER_BRIDGE-1:0] cmd_pattern(
        input logic [CMD_W-1:0] cmd,
        input logic             last_was_rev
    );
        logic [SW_PER_BRIDGE-1:0] pat;
        case (cmd)
            CMD_FWD:  pat = 4'b1001;
            CMD_REV:  pat = 4'b0110;
            CMD_SLOW: pat = 4'b1010;
            CMD_FAST: pat = last_was_rev ? 4'b1001 : 4'b0110;
            default:  pat = 4'b0000;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/hb_half_leg.sv
module hb_half_leg
    import hb_gate_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_hi,
    input  logic            req_lo,
    input  logic            kill,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate_hi,
    output logic            gate_lo
);

    typedef struct packed {
        logic            hi;
        logic            lo;
        logic [DT_W-1:0] idle;
        side_e           last;
    } leg_st_t;

    leg_st_t st_d, st_q;

    logic [DT_W-1:0] dt_eff;
    logic            gap_done;
    logic            hi_ok;
    logic            lo_ok;

    always_comb begin
        dt_eff   = (dead_cycles == '0) ? DT_W'(1) : dead_cycles;
        gap_done = (st_q.idle >= (dt_eff - DT_W'(1)));
        hi_ok    = !st_q.lo && ((st_q.last != SIDE_LO) || gap_done);
        lo_ok    = !st_q.hi && ((st_q.last != SIDE_HI) || gap_done);

        st_d    = st_q;
        st_d.hi = !kill && req_hi && (st_q.hi || hi_ok);
        st_d.lo = !kill && req_lo && !req_hi && (st_q.lo || lo_ok);

        if (st_q.hi) begin
            st_d.last = SIDE_HI;
        end else if (st_q.lo) begin
            st_d.last = SIDE_LO;
        end

        if (st_q.hi || st_q.lo) begin
            st_d.idle = '0;
        end else if (st_q.idle != '1) begin
            st_d.idle = st_q.idle + DT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hi: 1'b0, lo: 1'b0, idle: '0, last: SIDE_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_hi = st_q.hi;
    assign gate_lo = st_q.lo;

    p_leg_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo))
        else $error("leg shoot-through");

    p_hi_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) && ($past(dead_cycles) > DT_W'(1))) |-> !$past(gate_lo, 2))
        else $error("high-side rose without dead time");

    p_lo_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo) && ($past(dead_cycles) > DT_W'(1))) |-> !$past(gate_hi, 2))
        else $error("low-side rose without dead time");

    p_kill_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!gate_hi && !gate_lo))
        else $error("gate on after kill");

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_hi |=> !gate_hi)
        else $error("high-side held without request");

endmodule

// File: rtl/hb_bridge_ctl.sv
module hb_bridge_ctl
    import hb_gate_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [DT_W-1:0]          dead_cycles,
    input  logic [CMD_W-1:0]         cmd,
    input  logic [SW_PER_BRIDGE-1:0] desat,
    input  logic [SW_PER_BRIDGE-1:0] rev_cur,
    output logic [SW_PER_BRIDGE-1:0] gate,
    output logic                     fault
);

    localparam int LEGS = SW_PER_BRIDGE / 2;

    typedef struct packed {
        logic fault;
        logic dir_rev;
    } br_st_t;

    br_st_t st_d, st_q;

    logic [SW_PER_BRIDGE-1:0] base_req;
    logic [SW_PER_BRIDGE-1:0] sw_req;
    logic                     trip;
    logic                     kill;

    always_comb begin
        st_d     = st_q;
        trip     = |(desat & gate);
        st_d.fault = enable && (st_q.fault || trip);

        if (enable && (cmd == CMD_FWD)) begin
            st_d.dir_rev = 1'b0;
        end else if (enable && (cmd == CMD_REV)) begin
            st_d.dir_rev = 1'b1;
        end

        base_req = cmd_pattern(cmd, st_q.dir_rev);
        for (int i = 0; i < SW_PER_BRIDGE; i++) begin
            sw_req[i] = base_req[i] |
                        (rev_cur[i] & ~base_req[i ^ 1] & ~rev_cur[i ^ 1]);
        end

        kill = !enable || st_d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fault: 1'b0, dir_rev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.fault;

    for (genvar h = 0; h < LEGS; h++) begin : g_leg
        hb_half_leg #(.DT_W(DT_W)) i_leg (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_hi      (sw_req[2*h]),
            .req_lo      (sw_req[2*h+1]),
            .kill        (kill),
            .dead_cycles (dead_cycles),
            .gate_hi     (gate[2*h]),
            .gate_lo     (gate[2*h+1])
        );
    end

    p_desat_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && |(desat & gate)) |=> (fault && (gate == '0)))
        else $error("desaturation did not shut the bridge");

    p_fault_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (gate == '0))
        else $error("gate on while faulted");

    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && enable) |=> fault)
        else $error("fault dropped while enabled");

    p_fault_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fault)
        else $error("fault not cleared by disable");

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_gate_pkg::*;
#(
    parameter int NUM_BRIDGES = 2,
    parameter int DT_W        = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               drive_en,
    input  logic [DT_W-1:0]                    dead_cycles,
    input  logic [NUM_BRIDGES*CMD_W-1:0]       bridge_cmd,
    input  logic [NUM_BRIDGES*SW_PER_BRIDGE-1:0] desat_flag,
    input  logic [NUM_BRIDGES*SW_PER_BRIDGE-1:0] rev_flag,
    output logic [NUM_BRIDGES*SW_PER_BRIDGE-1:0] gate_on,
    output logic [NUM_BRIDGES-1:0]             bridge_fault
);

    localparam int SW_TOTAL = NUM_BRIDGES * SW_PER_BRIDGE;

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
        hb_bridge_ctl #(.DT_W(DT_W)) i_bridge (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (drive_en),
            .dead_cycles (dead_cycles),
            .cmd         (bridge_cmd[b*CMD_W +: CMD_W]),
            .desat       (desat_flag[b*SW_PER_BRIDGE +: SW_PER_BRIDGE]),
            .rev_cur     (rev_flag[b*SW_PER_BRIDGE +: SW_PER_BRIDGE]),
            .gate        (gate_on[b*SW_PER_BRIDGE +: SW_PER_BRIDGE]),
            .fault       (bridge_fault[b])
        );
    end

    p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> (gate_on == SW_TOTAL'(0)))
        else $error("gates on while disabled");

endmodule

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;

    localparam int NB = 2;
    localparam int DT_W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drive_en = 1'b0;
    logic [3:0] dead_cycles = 4'd3;
    logic [5:0] bridge_cmd = '0;
    logic [7:0] desat_flag = '0;
    logic [7:0] rev_flag = '0;
    logic [7:0] gate_on;
    logic [1:0] bridge_fault;

    hb_gate_seq #(.NUM_BRIDGES(NB), .DT_W(DT_W)) i_hb_gate_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .drive_en     (drive_en),
        .dead_cycles  (dead_cycles),
        .bridge_cmd   (bridge_cmd),
        .desat_flag   (desat_flag),
        .rev_flag     (rev_flag),
        .gate_on      (gate_on),
        .bridge_fault (bridge_fault)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string phase = "R1";

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_gate[8];
    int m_fault[2];
    int m_dir[2];     // 1 = last polarity was reverse
    int m_idle[4];    // cycles both switches of a leg have been off
    int m_last[4];    // 0 none, 1 high-side, 2 low-side

    function automatic int pat(input int code, input int dir_rev);
        case (code)
            1: return 9;
            2: return 6;
            3: return 10;
            4: return (dir_rev != 0) ? 9 : 6;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int ng[8];
        int nf[2];
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_gate[i] = 0;
            for (int i = 0; i < 4; i++) begin m_idle[i] = 0; m_last[i] = 0; end
            for (int i = 0; i < 2; i++) begin m_fault[i] = 0; m_dir[i] = 0; end
        end else begin
            for (int b = 0; b < 2; b++) begin
                int code;
                int base;
                int req[4];
                int hit;
                int dt;
                hit = 0;
                for (int k = 0; k < 4; k++)
                    if (desat_flag[b*4+k] && m_gate[b*4+k] != 0) hit = 1;
                nf[b] = drive_en ? ((m_fault[b] != 0 || hit != 0) ? 1 : 0) : 0;
                code = int'(bridge_cmd[b*3 +: 3]);
                base = pat(code, m_dir[b]);
                for (int k = 0; k < 4; k++) begin
                    int mate;
                    mate = k ^ 1;
                    req[k] = (base >> k) & 1;
                    if (rev_flag[b*4+k] && ((base >> mate) & 1) == 0 && !rev_flag[b*4+mate])
                        req[k] = 1;
                end
                dt = (dead_cycles == 0) ? 1 : int'(dead_cycles);
                for (int h = 0; h < 2; h++) begin
                    int leg;
                    int hi;
                    int lo;
                    bit waited;
                    leg = b*2 + h;
                    hi = b*4 + 2*h;
                    lo = hi + 1;
                    waited = (m_idle[leg] + 1 >= dt);
                    ng[hi] = 0;
                    ng[lo] = 0;
                    if (drive_en && nf[b] == 0) begin
                        if (req[2*h] != 0) begin
                            if (m_gate[hi] != 0) ng[hi] = 1;
                            else if (m_gate[lo] == 0 && (m_last[leg] != 2 || waited)) ng[hi] = 1;
                        end else if (req[2*h+1] != 0) begin
                            if (m_gate[lo] != 0) ng[lo] = 1;
                            else if (m_gate[hi] == 0 && (m_last[leg] != 1 || waited)) ng[lo] = 1;
                        end
                    end
                    if (m_gate[hi] != 0) m_last[leg] = 1;
                    else if (m_gate[lo] != 0) m_last[leg] = 2;
                    if (m_gate[hi] != 0 || m_gate[lo] != 0) m_idle[leg] = 0;
                    else if (m_idle[leg] < 15) m_idle[leg] = m_idle[leg] + 1;
                end
                if (drive_en && code == 1) m_dir[b] = 0;
                if (drive_en && code == 2) m_dir[b] = 1;
            end
            for (int i = 0; i < 8; i++) m_gate[i] = ng[i];
            for (int i = 0; i < 2; i++) m_fault[i] = nf[i];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int expv;
            expv = 0;
            for (int i = 0; i < 8; i++) expv |= (m_gate[i] << i);
            check_eq(phase, int'(gate_on), expv);
            check_eq(phase, int'(bridge_fault), m_fault[0] | (m_fault[1] << 1));
            for (int l = 0; l < 4; l++)
                check_eq("R3", int'(gate_on[2*l] & gate_on[2*l+1]), 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // counts all-off cycles of bridge 0 before pattern appears
    task automatic gap_to(input logic [3:0] want, output int gap);
        gap = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (gate_on[3:0] == want) break;
            if (gate_on[3:0] == 4'b0000) gap++;
        end
    endtask

    initial begin
        int gap;
        step(3);
        check_eq("R1", int'(gate_on), 0);
        check_eq("R1", int'(bridge_fault), 0);
        rst_n = 1'b1;
        step(2);

        phase = "R2";
        drive_en = 1'b1;
        dead_cycles = 4'd3;
        bridge_cmd = {3'b010, 3'b001};
        step(3);
        check_eq("R2", int'(gate_on[3:0]), 4'b1001);
        check_eq("R2", int'(gate_on[7:4]), 4'b0110);

        phase = "R4";
        bridge_cmd[2:0] = 3'b010;
        gap_to(4'b0110, gap);
        check_eq("R4", gap, 3);
        dead_cycles = 4'd0;
        bridge_cmd[2:0] = 3'b001;
        gap_to(4'b1001, gap);
        check_eq("R4", gap, 1);
        dead_cycles = 4'd15;
        bridge_cmd[2:0] = 3'b010;
        gap_to(4'b0110, gap);
        check_eq("R4", gap, 15);
        dead_cycles = 4'd2;
        bridge_cmd[2:0] = 3'b001;
        step(20);

        phase = "R5";
        bridge_cmd[2:0] = 3'b011;
        step(20);
        check_eq("R2", int'(gate_on[3:0]), 4'b1010);
        bridge_cmd[2:0] = 3'b100;
        step(20);
        check_eq("R5", int'(gate_on[3:0]), 4'b0110);
        bridge_cmd[2:0] = 3'b010;
        step(20);
        bridge_cmd[2:0] = 3'b100;
        step(20);
        check_eq("R5", int'(gate_on[3:0]), 4'b1001);

        phase = "R2";
        for (int c = 5; c < 8; c++) begin
            bridge_cmd[2:0] = 3'(c);
            step(4);
            check_eq("R2", int'(gate_on[3:0]), 0);
        end

        phase = "R9";
        bridge_cmd[2:0] = 3'b001;
        step(20);
        bridge_cmd[2:0] = 3'b000;
        step(1);
        check_eq("R9", int'(gate_on[3:0]), 0);

        phase = "R8";
        rev_flag[1] = 1'b1;
        step(20);
        check_eq("R8", int'(gate_on[3:0]), 4'b0010);
        rev_flag[1] = 1'b0;
        step(2);
        check_eq("R8", int'(gate_on[3:0]), 0);
        bridge_cmd[2:0] = 3'b001;
        rev_flag[1] = 1'b1;
        step(20);
        check_eq("R8", int'(gate_on[3:0]), 4'b1001);
        // flag raised on a leg while it is inside a dead-time window
        bridge_cmd[2:0] = 3'b011;
        rev_flag[1] = 1'b0;
        step(1);
        rev_flag[0] = 1'b1;
        step(20);
        check_eq("R8", int'(gate_on[3:0]), 4'b1010);
        rev_flag = '0;

        phase = "R6";
        bridge_cmd = {3'b001, 3'b001};
        step(20);
        desat_flag[1] = 1'b1;     // off switch: no effect
        step(1);
        desat_flag[1] = 1'b0;
        step(1);
        check_eq("R6", int'(bridge_fault), 0);
        desat_flag[4] = 1'b1;
        bridge_cmd[5:3] = 3'b010; // trip coincides with a new command
        step(1);
        desat_flag[4] = 1'b0;
        check_eq("R6", int'(bridge_fault), 2'b10);
        check_eq("R6", int'(gate_on[7:4]), 0);
        check_eq("R6", int'(gate_on[3:0]), 4'b1001);

        phase = "R7";
        bridge_cmd[5:3] = 3'b011;
        step(20);
        check_eq("R7", int'(bridge_fault), 2'b10);
        check_eq("R7", int'(gate_on[7:4]), 0);
        drive_en = 1'b0;
        step(1);
        check_eq("R7", int'(bridge_fault), 0);
        check_eq("R1", int'(gate_on), 0);
        drive_en = 1'b1;
        step(20);
        check_eq("R7", int'(gate_on[7:4]), 4'b1010);

        phase = "R3";
        for (int n = 0; n < 2500; n++) begin
            if ($urandom_range(0, 3) == 0) bridge_cmd = 6'($urandom);
            rev_flag = ($urandom_range(0, 5) == 0) ? 8'($urandom) : '0;
            desat_flag = ($urandom_range(0, 60) == 0) ? 8'($urandom) : '0;
            if ($urandom_range(0, 80) == 0) drive_en = ~drive_en;
            if ($urandom_range(0, 100) == 0) drive_en = 1'b1;
            if ($urandom_range(0, 40) == 0) dead_cycles = 4'($urandom_range(0, 6));
            step(1);
        end
        drive_en = 1'b1;
        step(5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule